// File: doc/BRIEF.md
# Chainable Down-Counting Interval Timer

This block holds a set of down-counting timer channels behind a single-cycle register port. Each channel counts down from a programmable reload value. When a count event finds the counter at zero, the channel reloads and raises a sticky expiry flag. That flag can also drive the channel's interrupt line. Software sets a period of N count events by writing N-1.

Any channel above the lowest can be linked to its lower neighbour. A linked channel then counts that neighbour's expiries instead of clock cycles. This gives periods longer than one counter can reach. With channels 0 and 1 linked and both reload values at all ones, the pair forms a free-running 64-bit lifetime counter. Reading the upper half of that counter captures the lower half, so the two reads return one coherent value.

A module-level halt bit stops every channel and locks out all register writes except writes to the halt bit itself. The halt bit is set out of reset.

Top module: `cascade_timer`

## Requirements
- R1: After reset, the mode register (word address 0, bit 0 = halt) reads 1. Every reload, count, control and flag register reads 0, and every irq line is low.
- R2: While halt is 1, no counter changes and writes to any address other than 0 are ignored. This includes flag clears.
- R3: An enabled, unlinked channel decrements once per clock. When a count event finds the counter at zero, the counter reloads and the flag is set. With reload N-1 the flag is set every N cycles.
- R4: When a control write turns the enable bit from 0 to 1, the counter is loaded from the reload value. A reload write to a running channel changes only the value taken at the next reload.
- R5: Writing 1 to flag bit 0 clears the flag and writing 0 has no effect. An expiry in the same cycle as a clear wins.
- R6: irq[n] is high exactly when channel n's flag and its interrupt-enable bit are both 1.
- R7: A channel n > 0 with its link bit set decrements once per expiry of channel n-1 and holds in all other cycles.
- R8: The link bit of channel 0 always reads 0, even after a write of 1.
- R9: A read of word address 1 returns channel 1's counter and captures channel 0's counter in the same cycle. A read of word address 2 returns that captured value.
- R10: Read data appears on the cycle after the read strobe. Unmapped addresses read 0. Channel n occupies word addresses 4+4n (reload), 5+4n (count), 6+4n (control: bit 0 enable, bit 1 interrupt enable, bit 2 link) and 7+4n (flag, bit 0).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | ADDR_W | Word address |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data, registered |
| irq | output | NUM_CH | Per-channel interrupt lines |

## Verification
The hardest state to reach is a lifetime pair in which the upper half has already moved. Channel 0 would need billions of cycles to wrap from an all-ones reload. The stimulus avoids this by starting channel 0 from a small reload value, then writing all ones into its reload while it runs. Its first expiry decrements the linked upper channel, and its next reload switches it to the full-width period. The bench then reads the high and low words several cycles apart to show that the low word comes from the snapshot and not from the live counter.

// File: rtl/cascade_timer_pkg.sv
package cascade_timer_pkg;

   // word addresses of the shared registers
   localparam int unsigned A_MODE    = 0;
   localparam int unsigned A_LIFE_HI = 1;
   localparam int unsigned A_LIFE_LO = 2;

   // channel register window
   localparam int unsigned CH_BASE    = 4;
   localparam int unsigned CH_SPAN    = 4;
   localparam int unsigned OFS_RELOAD = 0;
   localparam int unsigned OFS_COUNT  = 1;
   localparam int unsigned OFS_CTRL   = 2;
   localparam int unsigned OFS_STATUS = 3;

   typedef struct packed {
      logic link;
      logic irqen;
      logic run;
   } ctrl_t;

   function automatic int unsigned ch_addr(input int unsigned ch, input int unsigned ofs);
      return CH_BASE + ch * CH_SPAN + ofs;
   endfunction

endpackage

// File: rtl/cascade_timer_chan.sv
module cascade_timer_chan
   import cascade_timer_pkg::*;
#(
   parameter int unsigned CNT_W    = 32,
   parameter bit          LINKABLE = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             active,
   input  logic             reload_we,
   input  logic             ctrl_we,
   input  logic             status_we,
   input  logic [CNT_W-1:0] wr_val,
   input  ctrl_t            wr_ctrl,
   input  logic             wr_clr,
   input  logic             pred_expire,
   output logic             expire,
   output logic [CNT_W-1:0] count,
   output logic [CNT_W-1:0] reload,
   output ctrl_t            ctrl,
   output logic             flag
);

   logic [CNT_W-1:0] count_q;
   logic [CNT_W-1:0] reload_q;
   ctrl_t            ctrl_q;
   ctrl_t            wr_ctrl_eff;
   logic             flag_q;
   logic             linked;
   logic             tick;
   logic             at_zero;

   generate
      if (LINKABLE) begin : g_link
         assign wr_ctrl_eff = wr_ctrl;
         assign linked      = ctrl_q.link;
      end else begin : g_nolink
         assign wr_ctrl_eff = {1'b0, wr_ctrl.irqen, wr_ctrl.run};
         assign linked      = 1'b0;
      end
   endgenerate

   assign tick    = active & ctrl_q.run & (linked ? pred_expire : 1'b1);
   assign at_zero = (count_q == '0);
   assign expire  = tick & at_zero;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         count_q  <= '0;
         reload_q <= '0;
         ctrl_q   <= '0;
         flag_q   <= 1'b0;
      end else begin
         if (reload_we) reload_q <= wr_val;
         if (ctrl_we)   ctrl_q   <= wr_ctrl_eff;
         if (ctrl_we && wr_ctrl_eff.run && !ctrl_q.run)
            count_q <= reload_q;
         else if (tick)
            count_q <= at_zero ? reload_q : count_q - 1'b1;
         if (expire)
            flag_q <= 1'b1;
         else if (status_we && wr_clr)
            flag_q <= 1'b0;
      end
   end

   assign count  = count_q;
   assign reload = reload_q;
   assign ctrl   = ctrl_q;
   assign flag   = flag_q;

endmodule

// File: rtl/cascade_timer_rd.sv
module cascade_timer_rd
   import cascade_timer_pkg::*;
#(
   parameter int unsigned NUM_CH = 4,
   parameter int unsigned CNT_W  = 32,
   parameter int unsigned ADDR_W = 6,
   parameter int unsigned DATA_W = 32
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic                         rd,
   input  logic [ADDR_W-1:0]            addr,
   input  logic                         halt,
   input  logic [NUM_CH-1:0][CNT_W-1:0] count,
   input  logic [NUM_CH-1:0][CNT_W-1:0] reload,
   input  ctrl_t [NUM_CH-1:0]           ctrl,
   input  logic [NUM_CH-1:0]            flag,
   output logic [DATA_W-1:0]            rdata
);

   localparam logic [ADDR_W-1:0] AD_MODE = ADDR_W'(A_MODE);
   localparam logic [ADDR_W-1:0] AD_HI   = ADDR_W'(A_LIFE_HI);
   localparam logic [ADDR_W-1:0] AD_LO   = ADDR_W'(A_LIFE_LO);

   logic [DATA_W-1:0] nxt;
   logic [CNT_W-1:0]  snap_q;

   always_comb begin
      nxt = '0;
      if (addr == AD_MODE) nxt = DATA_W'(halt);
      if (addr == AD_HI)   nxt = DATA_W'(count[1]);
      if (addr == AD_LO)   nxt = DATA_W'(snap_q);
      for (int k = 0; k < NUM_CH; k++) begin
         if (addr == ADDR_W'(ch_addr(k, OFS_RELOAD))) nxt = DATA_W'(reload[k]);
         if (addr == ADDR_W'(ch_addr(k, OFS_COUNT)))  nxt = DATA_W'(count[k]);
         if (addr == ADDR_W'(ch_addr(k, OFS_CTRL)))   nxt = DATA_W'(ctrl[k]);
         if (addr == ADDR_W'(ch_addr(k, OFS_STATUS))) nxt = DATA_W'(flag[k]);
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rdata  <= '0;
         snap_q <= '0;
      end else if (rd) begin
         rdata <= nxt;
         if (addr == AD_HI) snap_q <= count[0];
      end
   end

endmodule

// File: rtl/cascade_timer.sv
module cascade_timer
   import cascade_timer_pkg::*;
#(
   parameter int unsigned NUM_CH = 4,
   parameter int unsigned CNT_W  = 32,
   parameter int unsigned ADDR_W = 6,
   parameter int unsigned DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_wr,
   input  logic              bus_rd,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   output logic [NUM_CH-1:0] irq
);

   localparam int unsigned TOP_ADDR = CH_BASE + NUM_CH * CH_SPAN - 1;

   generate
      if (NUM_CH < 2) begin : g_bad_nch
         $error("cascade_timer: a lifetime pair needs at least two channels");
      end
      if (CNT_W > DATA_W) begin : g_bad_cnt
         $error("cascade_timer: counter wider than the data bus");
      end
      if (TOP_ADDR >= (1 << ADDR_W)) begin : g_bad_addr
         $error("cascade_timer: channel window does not fit the address width");
      end
   endgenerate

   logic                         halt_q;
   logic                         wr_ok;
   logic [NUM_CH-1:0][CNT_W-1:0] cnt_v;
   logic [NUM_CH-1:0][CNT_W-1:0] rl_v;
   ctrl_t [NUM_CH-1:0]           ctl_v;
   logic [NUM_CH-1:0]            flag_v;
   logic [NUM_CH-1:0]            exp_v;
   logic [NUM_CH-1:0]            rl_we;
   logic [NUM_CH-1:0]            ctl_we;
   logic [NUM_CH-1:0]            st_we;
   logic [NUM_CH-1:0]            pred_v;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         halt_q <= 1'b1;
      else if (bus_wr && bus_addr == ADDR_W'(A_MODE))
         halt_q <= bus_wdata[0];
   end

   assign wr_ok = bus_wr & ~halt_q;

   genvar k;
   generate
      for (k = 0; k < NUM_CH; k++) begin : g_ch
         localparam logic [ADDR_W-1:0] AD_RL = ADDR_W'(CH_BASE + k * CH_SPAN + OFS_RELOAD);
         localparam logic [ADDR_W-1:0] AD_CT = ADDR_W'(CH_BASE + k * CH_SPAN + OFS_CTRL);
         localparam logic [ADDR_W-1:0] AD_ST = ADDR_W'(CH_BASE + k * CH_SPAN + OFS_STATUS);

         assign rl_we[k]  = wr_ok && bus_addr == AD_RL;
         assign ctl_we[k] = wr_ok && bus_addr == AD_CT;
         assign st_we[k]  = wr_ok && bus_addr == AD_ST;

         if (k == 0) begin : g_first
            assign pred_v[k] = 1'b0;
         end else begin : g_next
            assign pred_v[k] = exp_v[k-1];
         end

         cascade_timer_chan #(
            .CNT_W    (CNT_W),
            .LINKABLE (k != 0)
         ) u_chan (
            .clk         (clk),
            .rst_n       (rst_n),
            .active      (~halt_q),
            .reload_we   (rl_we[k]),
            .ctrl_we     (ctl_we[k]),
            .status_we   (st_we[k]),
            .wr_val      (bus_wdata[CNT_W-1:0]),
            .wr_ctrl     (ctrl_t'(bus_wdata[2:0])),
            .wr_clr      (bus_wdata[0]),
            .pred_expire (pred_v[k]),
            .expire      (exp_v[k]),
            .count       (cnt_v[k]),
            .reload      (rl_v[k]),
            .ctrl        (ctl_v[k]),
            .flag        (flag_v[k])
         );

         assign irq[k] = flag_v[k] & ctl_v[k].irqen;
      end
   endgenerate

   cascade_timer_rd #(
      .NUM_CH (NUM_CH),
      .CNT_W  (CNT_W),
      .ADDR_W (ADDR_W),
      .DATA_W (DATA_W)
   ) u_rd (
      .clk    (clk),
      .rst_n  (rst_n),
      .rd     (bus_rd),
      .addr   (bus_addr),
      .halt   (halt_q),
      .count  (cnt_v),
      .reload (rl_v),
      .ctrl   (ctl_v),
      .flag   (flag_v),
      .rdata  (bus_rdata)
   );

endmodule

// File: rtl/cascade_timer_chk.sv
module cascade_timer_chk
   import cascade_timer_pkg::*;
#(
   parameter int unsigned NUM_CH = 4,
   parameter int unsigned CNT_W  = 32
) (
   input logic                         clk,
   input logic                         rst_n,
   input logic                         halt,
   input logic [NUM_CH-1:0][CNT_W-1:0] cnt,
   input logic [NUM_CH-1:0][CNT_W-1:0] rl,
   input ctrl_t [NUM_CH-1:0]           ctl,
   input logic [NUM_CH-1:0]            flag,
   input logic [NUM_CH-1:0]            expire,
   input logic [NUM_CH-1:0]            ctl_we,
   input logic [NUM_CH-1:0]            irq
);

   // R2
   halt_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
      halt |=> $stable(cnt));

   // R6
   irq_needs_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (irq & ~flag) == '0);

   genvar k;
   generate
      for (k = 0; k < NUM_CH; k++) begin : g_chk
         // R3
         flag_from_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(flag[k]) |-> $past(cnt[k]) == '0);

         // R4
         count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !$stable(cnt[k]) |-> (cnt[k] == CNT_W'($past(cnt[k]) - 1'b1)) ||
                                 (cnt[k] == $past(rl[k])));

         if (k > 0) begin : g_linked
            // R7
            link_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
               (ctl[k].link && !expire[k-1] && !ctl_we[k]) |=> $stable(cnt[k]));
         end
      end
   endgenerate

endmodule

bind cascade_timer cascade_timer_chk #(
   .NUM_CH (NUM_CH),
   .CNT_W  (CNT_W)
) u_chk (
   .clk    (clk),
   .rst_n  (rst_n),
   .halt   (halt_q),
   .cnt    (cnt_v),
   .rl     (rl_v),
   .ctl    (ctl_v),
   .flag   (flag_v),
   .expire (exp_v),
   .ctl_we (ctl_we),
   .irq    (irq)
);

// File: tb/cascade_timer_bench.sv
module cascade_timer_bench;

   localparam int NCH = 4;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_wr = 1'b0;
   logic        bus_rd = 1'b0;
   logic [5:0]  bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic [3:0]  irq;

   always #2.5 clk = ~clk;

   cascade_timer u_cascade_timer (
      .clk       (clk),
      .rst_n     (rst_n),
      .bus_wr    (bus_wr),
      .bus_rd    (bus_rd),
      .bus_addr  (bus_addr),
      .bus_wdata (bus_wdata),
      .bus_rdata (bus_rdata),
      .irq       (irq)
   );

   // behavioural reference state
   logic [31:0] m_cnt  [NCH];
   logic [31:0] m_load [NCH];
   bit          m_en   [NCH];
   bit          m_ie   [NCH];
   bit          m_ln   [NCH];
   bit          m_flag [NCH];
   bit          m_halt;
   logic [31:0] m_snap;
   logic [31:0] m_rd;

   int vectors = 0;
   int errors  = 0;
   bit done    = 1'b0;

   task automatic model_reset();
      for (int k = 0; k < NCH; k++) begin
         m_cnt[k] = 0; m_load[k] = 0; m_en[k] = 0; m_ie[k] = 0; m_ln[k] = 0; m_flag[k] = 0;
      end
      m_halt = 1; m_snap = 0; m_rd = 0;
   endtask

   task automatic model_step(input bit w, input bit r, input int a, input logic [31:0] d);
      logic [31:0] n_cnt [NCH];
      logic [31:0] n_load[NCH];
      bit n_en[NCH], n_ie[NCH], n_ln[NCH], n_flag[NCH];
      bit prev_exp;
      bit wok;
      prev_exp = 0;
      wok = w && !m_halt;
      for (int k = 0; k < NCH; k++) begin
         bit ln, ev, ex;
         int base;
         n_cnt[k] = m_cnt[k]; n_load[k] = m_load[k]; n_en[k] = m_en[k];
         n_ie[k] = m_ie[k]; n_ln[k] = m_ln[k]; n_flag[k] = m_flag[k];
         base = 4 + 4 * k;
         ln = (k > 0) && m_ln[k];
         ev = !m_halt && m_en[k] && (ln ? prev_exp : 1'b1);
         ex = ev && (m_cnt[k] == 0);
         if (wok && a == base) n_load[k] = d;
         if (wok && a == base + 2) begin
            n_en[k] = d[0]; n_ie[k] = d[1]; n_ln[k] = (k > 0) ? d[2] : 1'b0;
         end
         if (wok && a == base + 2 && d[0] && !m_en[k]) n_cnt[k] = m_load[k];
         else if (ev) n_cnt[k] = ex ? m_load[k] : m_cnt[k] - 1;
         if (ex) n_flag[k] = 1;
         else if (wok && a == base + 3 && d[0]) n_flag[k] = 0;
         prev_exp = ex;
      end
      if (r) begin
         m_rd = 0;
         if (a == 0) m_rd = {31'd0, m_halt};
         if (a == 1) m_rd = m_cnt[1];
         if (a == 2) m_rd = m_snap;
         for (int k = 0; k < NCH; k++) begin
            if (a == 4 + 4 * k) m_rd = m_load[k];
            if (a == 5 + 4 * k) m_rd = m_cnt[k];
            if (a == 6 + 4 * k) m_rd = {29'd0, m_ln[k], m_ie[k], m_en[k]};
            if (a == 7 + 4 * k) m_rd = {31'd0, m_flag[k]};
         end
         if (a == 1) m_snap = m_cnt[0];
      end
      if (w && a == 0) m_halt = d[0];
      for (int k = 0; k < NCH; k++) begin
         m_cnt[k] = n_cnt[k]; m_load[k] = n_load[k]; m_en[k] = n_en[k];
         m_ie[k] = n_ie[k]; m_ln[k] = n_ln[k]; m_flag[k] = n_flag[k];
      end
   endtask

   function automatic logic [3:0] exp_irq();
      logic [3:0] v;
      for (int k = 0; k < NCH; k++) v[k] = m_flag[k] & m_ie[k];
      return v;
   endfunction

   // one bus cycle: drive, clock, update model, compare away from the edge
   task automatic cyc(input bit w, input bit r, input int a, input logic [31:0] d, input string tag);
      bus_wr = w; bus_rd = r; bus_addr = 6'(a); bus_wdata = d;
      @(posedge clk);
      model_step(w, r, a, d);
      @(negedge clk);
      vectors++;
      if (irq !== exp_irq()) begin
         errors++;
         $display("FAIL R6 irq actual %b expected %b", irq, exp_irq());
      end
      if (r) begin
         vectors++;
         if (bus_rdata !== m_rd) begin
            errors++;
            $display("FAIL %s read addr %0d actual %h expected %h", tag, a, bus_rdata, m_rd);
         end
      end
      bus_wr = 0; bus_rd = 0;
   endtask

   task automatic wr(input int a, input logic [31:0] d, input string tag);
      cyc(1, 0, a, d, tag);
   endtask

   task automatic rd(input int a, input string tag);
      cyc(0, 1, a, 32'd0, tag);
   endtask

   initial begin
      repeat (50000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog actual timeout expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
         $finish;
      end
   end

   initial begin
      model_reset();
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset values
      rd(0, "R1"); rd(4, "R1"); rd(5, "R1"); rd(6, "R1"); rd(7, "R1"); rd(2, "R1");

      // R2 writes ignored while halted
      wr(4, 32'd7, "R2"); wr(6, 32'd1, "R2"); wr(8, 32'd5, "R2");
      rd(4, "R2"); rd(6, "R2"); rd(8, "R2"); rd(5, "R2");
      wr(0, 32'd0, "R2"); rd(0, "R2");

      // R3 free-running channel, period 5
      wr(4, 32'd4, "R3"); wr(6, 32'd3, "R3");
      for (int i = 0; i < 14; i++) rd(5, "R3");

      // R5 flag write-one-to-clear
      wr(7, 32'd0, "R5"); rd(7, "R5");
      wr(7, 32'd1, "R5"); rd(7, "R5");
      for (int i = 0; i < 6; i++) rd(7, "R5");

      // R8 link bit on channel 0 stays clear
      wr(6, 32'd7, "R8"); rd(6, "R8");

      // R7 linked channel counts expiries of its neighbour
      wr(8, 32'd2, "R7"); wr(10, 32'd7, "R7");
      for (int i = 0; i < 40; i++) rd(9, "R7");
      rd(11, "R7");

      // R4 reload change at next reload; enable loads counter
      wr(4, 32'd9, "R4");
      for (int i = 0; i < 25; i++) rd(5, "R4");
      wr(12, 32'd6, "R4"); wr(14, 32'd1, "R4");
      for (int i = 0; i < 4; i++) rd(13, "R4");
      wr(12, 32'd2, "R4");
      for (int i = 0; i < 10; i++) rd(13, "R4");

      // R10 unmapped addresses
      rd(3, "R10"); rd(63, "R10"); rd(40, "R10");

      // R9 lifetime pair
      wr(6, 32'd0, "R9"); wr(10, 32'd0, "R9");
      wr(4, 32'd3, "R9"); wr(8, 32'hFFFF_FFFF, "R9");
      wr(6, 32'd1, "R9"); wr(10, 32'd5, "R9");
      wr(4, 32'hFFFF_FFFF, "R9");
      repeat (10) cyc(0, 0, 0, 32'd0, "R9");
      rd(1, "R9");
      repeat (3) cyc(0, 0, 0, 32'd0, "R9");
      rd(2, "R9"); rd(5, "R9"); rd(1, "R9"); rd(2, "R9");

      // R2 halt mid-run freezes and locks writes
      wr(14, 32'd3, "R2");
      repeat (3) cyc(0, 0, 0, 32'd0, "R2");
      wr(0, 32'd1, "R2");
      rd(5, "R2"); rd(5, "R2"); rd(13, "R2");
      wr(15, 32'd1, "R2"); rd(15, "R2");
      wr(4, 32'd1, "R2"); rd(4, "R2");
      wr(0, 32'd0, "R2");
      rd(5, "R2"); rd(13, "R2"); rd(15, "R2");

      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
   end

endmodule